// File: doc/BRIEF.md
# Bidirectional Serial Address Register

This block holds a memory address for a bit-serial processor whose general registers and program counter rotate one bit per cycle, least significant bit first. During a capture phase it takes the address in one bit per cycle, LSB first, either straight from the first operand or from the serial sum of both operands. During a replay phase it reverses its shift direction and sends the address out MSB first, one bit per cycle, toward the serial memory's data-in line. The memory expects address bits right after its command byte. A separate writeback bit returns either the sum or the unchanged first operand to the register file. This provides the post-increment and pre-increment addressing used for stack operations.

Read addresses and write addresses follow different timing. On a read, the MSB goes straight to the output on the last capture cycle without passing through the register. The replay then reads the remaining fifteen bits from the flop next to the top of the register. On a write, the whole address, all sixteen bits, leaves the top flop during the replay, so that the write data can follow it directly on the bus.

Top module: `bidir_addr_sreg`

## Requirements
- R1: After reset the stored address is zero. A replay right after reset emits sixteen zero bits.
- R2: While `cap_en` is high, one bit is shifted in per cycle, least significant bit first. `mode_i` bit 0 picks the source: 1 takes `sum_bit`, 0 takes `opa_bit`. After sixteen capture cycles the register holds the complete word.
- R3: `mode_i` bit 1 set makes `wb_bit` equal `sum_bit` in the same cycle. Clear, `wb_bit` equals `opa_bit`, which leaves the source register unchanged. Because the bit is returned in the cycle it is produced, a store whose data register is also the writeback register sees the updated value.
- R4: With `wr_timing` low, `addr_bit` shows the captured MSB during the sixteenth consecutive capture cycle. The next fifteen replay cycles then show bits 14 down to 0.
- R5: With `wr_timing` high, `addr_bit` stays 0 during capture. Sixteen replay cycles then show bits 15 down to 0.
- R6: With both `cap_en` and `rep_en` low, the stored address is held whatever `opa_bit` and `sum_bit` do.
- R7: When `cap_en` and `rep_en` are both high, capture wins. The captured word is unaffected.
- R8: The early MSB on a read appears only on the sixteenth consecutive capture cycle. A cycle with `cap_en` low restarts the count.
- R9: `addr_bit` is 0 in any cycle that is neither a replay cycle nor the early-MSB cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa_bit | input | 1 | Serial first operand, LSB first |
| sum_bit | input | 1 | Serial sum of both operands, LSB first |
| mode_i | input | 2 | Bit 0: capture the sum; bit 1: write the sum back |
| wr_timing | input | 1 | 1 selects write-address timing, 0 read timing |
| cap_en | input | 1 | Capture phase enable |
| rep_en | input | 1 | Replay phase enable |
| addr_bit | output | 1 | Serial address toward memory, MSB first |
| wb_bit | output | 1 | Serial writeback toward the register file |

## Verification
A wrong bit in the register shows up as a single wrong `addr_bit` during the next replay, at the position of that bit. A fault is therefore visible one to sixteen cycles into the replay. A wrong capture count shows at once: either the early MSB is missing on the sixteenth read-capture cycle, or it appears in a cycle where `addr_bit` must be 0. A wrong source or writeback selection shows on `wb_bit` in the same cycle, and in the replayed address one phase later.

// File: rtl/bidir_addr_pkg.sv
package bidir_addr_pkg;

    typedef struct packed {
        logic wb_sum;   // bit 1: write sum back to first-operand register
        logic use_sum;  // bit 0: capture the sum instead of the first operand
    } amode_t;

    function automatic amode_t decode_mode(input logic [1:0] raw);
        amode_t m;
        m.wb_sum  = raw[1];
        m.use_sum = raw[0];
        return m;
    endfunction

endpackage

// File: rtl/bidir_addr_src.sv
module bidir_addr_src
    import bidir_addr_pkg::*;
(
    input  amode_t mode,
    input  logic   opa_bit,
    input  logic   sum_bit,
    output logic   cap_bit,
    output logic   wb_bit
);

    always_comb begin
        cap_bit = mode.use_sum ? sum_bit : opa_bit;
        wb_bit  = mode.wb_sum  ? sum_bit : opa_bit;
    end

endmodule

// File: rtl/bidir_addr_count.sv
module bidir_addr_count #(
    parameter int AW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    output logic last_beat
);

    localparam int CW = (AW > 1) ? $clog2(AW) : 1;
    localparam logic [CW-1:0] LAST = CW'(AW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cap_en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_beat = cap_en && (st_q.cnt == LAST);

    // R8: a gap in capture restarts the beat count
    p_gap_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (st_q.cnt == '0));

    // R8: a run advances the count by one until it wraps
    p_run_advances_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/bidir_addr_core.sv
module bidir_addr_core #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          rep_en,
    input  logic          cap_bit,
    output logic [AW-1:0] q
);

    typedef struct packed {
        logic [AW-1:0] sreg;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            // towards LSB: new bit enters at the top
            st_d.sreg = {cap_bit, st_q.sreg[AW-1:1]};
        end else if (rep_en) begin
            // towards MSB: top bit leaves first
            st_d.sreg = {st_q.sreg[AW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.sreg;

    // R2 / R7: capture enters at the top even when replay is also requested
    p_capture_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (q[AW-1] == $past(cap_bit)) && (q[AW-2:0] == $past(q[AW-1:1])));

    // R4 / R5: replay moves contents toward the top
    p_replay_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_en && !cap_en) |=> (q[AW-1:1] == $past(q[AW-2:0])) && !q[0]);

    // R6: idle holds the address
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !rep_en) |=> $stable(q));

endmodule

// File: rtl/bidir_addr_tap.sv
module bidir_addr_tap #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] q,
    input  logic          cap_en,
    input  logic          rep_en,
    input  logic          wr_timing,
    input  logic          last_beat,
    input  logic          cap_bit,
    output logic          addr_bit
);

    localparam int WR_TAP = AW - 1;
    localparam int RD_TAP = AW - 2;

    logic rd_tap_bit;
    logic wr_tap_bit;

    generate
        if (AW >= 2) begin : g_taps
            assign rd_tap_bit = q[RD_TAP];
            assign wr_tap_bit = q[WR_TAP];
        end else begin : g_single
            assign rd_tap_bit = 1'b0;
            assign wr_tap_bit = q[0];
        end
    endgenerate

    always_comb begin
        addr_bit = 1'b0;
        if (cap_en) begin
            if (last_beat && !wr_timing) begin
                addr_bit = cap_bit;
            end
        end else if (rep_en) begin
            addr_bit = wr_timing ? wr_tap_bit : rd_tap_bit;
        end
    end

    // R9: quiet when idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !rep_en) |-> !addr_bit);

    // R5: write-timed capture never drives the line
    p_write_cap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && wr_timing) |-> !addr_bit);

    // R4: the bit sent early is the one that lands at the top of the register
    p_early_msb_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && last_beat && !wr_timing) |=> (q[AW-1] == $past(addr_bit)));

endmodule

// File: rtl/bidir_addr_sreg.sv
module bidir_addr_sreg
    import bidir_addr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       opa_bit,
    input  logic       sum_bit,
    input  logic [1:0] mode_i,
    input  logic       wr_timing,
    input  logic       cap_en,
    input  logic       rep_en,
    output logic       addr_bit,
    output logic       wb_bit
);

    amode_t        mode;
    logic          cap_bit;
    logic          last_beat;
    logic [AW-1:0] q;

    assign mode = decode_mode(mode_i);

    bidir_addr_src u_src (
        .mode    (mode),
        .opa_bit (opa_bit),
        .sum_bit (sum_bit),
        .cap_bit (cap_bit),
        .wb_bit  (wb_bit)
    );

    bidir_addr_count #(.AW(AW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .last_beat (last_beat)
    );

    bidir_addr_core #(.AW(AW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .rep_en  (rep_en),
        .cap_bit (cap_bit),
        .q       (q)
    );

    bidir_addr_tap #(.AW(AW)) u_tap (
        .clk       (clk),
        .rst_n     (rst_n),
        .q         (q),
        .cap_en    (cap_en),
        .rep_en    (rep_en),
        .wr_timing (wr_timing),
        .last_beat (last_beat),
        .cap_bit   (cap_bit),
        .addr_bit  (addr_bit)
    );

    // R3: with writeback off the register file gets its own operand back
    p_no_wb_recirc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !mode_i[1]) |-> (wb_bit == opa_bit));

endmodule

// File: tb/bidir_addr_sreg_tb.sv
`timescale 1ns/1ps
module bidir_addr_sreg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       opa_bit = 1'b0;
    logic       sum_bit = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       wr_timing = 1'b0;
    logic       cap_en = 1'b0;
    logic       rep_en = 1'b0;
    logic       addr_bit;
    logic       wb_bit;

    int n_vec = 0;
    int n_bad = 0;
    logic quiet_ok;

    always #10 clk = ~clk;

    bidir_addr_sreg dut_i (
        .clk(clk), .rst_n(rst_n), .opa_bit(opa_bit), .sum_bit(sum_bit),
        .mode_i(mode_i), .wr_timing(wr_timing), .cap_en(cap_en),
        .rep_en(rep_en), .addr_bit(addr_bit), .wb_bit(wb_bit)
    );

    localparam int NV = 8;
    localparam logic [15:0] TA [NV] = '{16'h1234, 16'hFFFE, 16'h8000, 16'h0F0F,
                                        16'hA5A5, 16'h7FFF, 16'h0000, 16'hC3C3};
    localparam logic [15:0] TB [NV] = '{16'h0002, 16'h0002, 16'h8000, 16'hFFFE,
                                        16'h5A5B, 16'h0001, 16'hFFFF, 16'h1111};
    localparam logic [1:0]  TM [NV] = '{2'b00, 2'b10, 2'b01, 2'b11,
                                        2'b01, 2'b11, 2'b10, 2'b00};
    localparam logic        TW [NV] = '{1'b0, 1'b1, 1'b0, 1'b1,
                                        1'b1, 1'b0, 1'b0, 1'b1};

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // capture 16 bits then replay; idle_gap idle cycles in between
    task automatic xfer(input logic [15:0] a, input logic [15:0] b, input logic [1:0] m,
                        input logic wr, input logic rep_in_cap, input int idle_gap,
                        output logic [15:0] got_addr, output logic [15:0] got_wb);
        logic c;
        c = 1'b0;
        got_addr = '0;
        got_wb = '0;
        quiet_ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            opa_bit = a[i];
            sum_bit = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
            mode_i = m;
            wr_timing = wr;
            cap_en = 1'b1;
            rep_en = rep_in_cap;
            #5;
            got_wb[i] = wb_bit;
            if (i == 15 && !wr) got_addr[15] = addr_bit;
            else if (addr_bit !== 1'b0) quiet_ok = 1'b0;
        end
        for (int g = 0; g < idle_gap; g++) begin
            @(negedge clk);
            cap_en = 1'b0;
            rep_en = 1'b0;
            opa_bit = g[0];
            sum_bit = ~g[0];
            #5;
            if (addr_bit !== 1'b0) quiet_ok = 1'b0;
        end
        for (int j = (wr ? 15 : 14); j >= 0; j--) begin
            @(negedge clk);
            cap_en = 1'b0;
            rep_en = 1'b1;
            opa_bit = 1'b1;
            sum_bit = 1'b1;
            #5;
            got_addr[j] = addr_bit;
        end
        @(negedge clk);
        rep_en = 1'b0;
        opa_bit = 1'b0;
        sum_bit = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] ga, gw, s, ea, ew;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state replays as zero, R9 quiet at idle
        @(negedge clk); #5;
        check("R9 idle after reset", {15'd0, addr_bit}, 16'h0000);
        ga = '0;
        for (int j = 15; j >= 0; j--) begin
            @(negedge clk); rep_en = 1'b1; wr_timing = 1'b1; #5;
            ga[j] = addr_bit;
        end
        @(negedge clk); rep_en = 1'b0;
        check("R1 replay after reset", ga, 16'h0000);

        // table walk: R2 source select, R3 writeback, R4 read timing, R5 write timing
        for (int v = 0; v < NV; v++) begin
            s = TA[v] + TB[v];
            ea = TM[v][0] ? s : TA[v];
            ew = TM[v][1] ? s : TA[v];
            xfer(TA[v], TB[v], TM[v], TW[v], 1'b0, 0, ga, gw);
            check(TW[v] ? "R2/R5 address" : "R2/R4 address", ga, ea);
            check("R3 writeback", gw, ew);
            check("R9 capture quiet", {15'd0, quiet_ok}, 16'h0001);
        end

        // R6: idle gap with toggling operands keeps the address
        xfer(16'hBEEF, 16'h0101, 2'b01, 1'b0, 1'b0, 5, ga, gw);
        check("R6 hold across idle", ga, 16'hBFF0);
        check("R9 quiet during idle", {15'd0, quiet_ok}, 16'h0001);

        // R7: replay request during capture is ignored
        xfer(16'h5555, 16'h1111, 2'b01, 1'b1, 1'b1, 0, ga, gw);
        check("R7 capture priority", ga, 16'h6666);

        // R8: a broken run must not trigger the early MSB
        quiet_ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cap_en = 1'b1; rep_en = 1'b0; wr_timing = 1'b0; mode_i = 2'b00;
            opa_bit = 1'b1; sum_bit = 1'b1;
            #5;
            if (addr_bit !== 1'b0) quiet_ok = 1'b0;
        end
        @(negedge clk); cap_en = 1'b0; #5;
        if (addr_bit !== 1'b0) quiet_ok = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cap_en = 1'b1; opa_bit = 1'b1;
            #5;
            if (addr_bit !== 1'b0) quiet_ok = 1'b0;
        end
        @(negedge clk); cap_en = 1'b0;
        check("R8 no early bit on broken run", {15'd0, quiet_ok}, 16'h0001);
        xfer(16'h8421, 16'h0000, 2'b00, 1'b0, 1'b0, 0, ga, gw);
        check("R8 full run after restart", ga, 16'h8421);

        // R3: pre-increment style, sum written back
        xfer(16'h0100, 16'hFFFE, 2'b11, 1'b1, 1'b0, 0, ga, gw);
        check("R3 updated value returned", gw, 16'h00FE);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule